// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a narrow window onto a bank of 32-bit control and status registers. The host sees only two locations. One is a pointer that holds a register number. The other is a 16-bit data window that reads or writes one half of the register the pointer selects.

Bit 1 of the pointer chooses the half. Every access to the data window flips that bit, whether it is a read or a write. So after one pointer write, two data accesses cover the low half first and then the high half of the same register.

The bank behind the window holds three registers:
- an interrupt mask that keeps 23 bits;
- a read-only slot number, taken from strap pins;
- a 32-bit scratch register that software can use for debug tracing.

The host interface is a single-cycle strobe with a byte offset, a write enable and 16-bit data in each direction. Read data is registered. It appears on the cycle after the read strobe.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, the pointer, the mask and the scratch register are all zero, and `rdata` is zero.
- R2: A strobed write at offset 0 loads the pointer from `wdata[7:0]`. A strobed read at offset 0 returns the pointer in bits 7:0 and zero in bits 15:8. Accesses at offset 0 do not change pointer bit 1.
- R3: Every strobed access at offset 4, read or write, inverts pointer bit 1. Pointer bits 7:2 and bit 0 are left unchanged.
- R4: A data-window access reaches bits 15:0 of the selected register when pointer bit 1 is 0, and bits 31:16 when it is 1. The register is selected by pointer bits 7:2.
- R5: The interrupt mask is register number 0x08. It stores only bits 22:0. Writes to bits 31:23 are dropped, and those bits read as zero.
- R6: The slot register is register number 0x10. It returns `slot_strap` in bits 3:0 and zero in all other bits. Writes to it have no effect, but they still toggle pointer bit 1.
- R7: The scratch register is register number 0x18. All 32 bits can be written and read back.
- R8: Any other register number reads as zero, and writes to it change no register.
- R9: A pointer write sets bit 1 to the value written. Later toggles start from that value.
- R10: `rdata` changes only on the clock edge that ends a strobed read. It holds its value through idle cycles and through writes.
- R11: A strobe at an offset other than 0 or 4 changes neither the pointer nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Access request, valid for one cycle |
| addr | input | 3 | Byte offset: 0 is the pointer, 4 is the data window |
| wr_en | input | 1 | 1 for a write, 0 for a read |
| wdata | input | 16 | Write data |
| slot_strap | input | 4 | Slot number presented by the slot register |
| rdata | output | 16 | Registered read data |

## Verification
A pointer half-select that is stuck or flipped shows up on the very next data-window read: the wrong half comes back, or the pointer itself reads back with the wrong bit 1 one cycle after an offset-0 read. A register decode that is wrong shows up when a value written to one register number reads back from another number, or when data is lost, within a few accesses. A mask that keeps too many bits exposes nonzero upper bits in the read that follows a write of all ones to the high half.

// File: rtl/ind_reg_port.sv
module ind_reg_port #(
  parameter int PTR_W       = 8,
  parameter int MASK_BITS   = 23,
  parameter int SLOT_W      = 4,
  parameter int MASK_NUM    = 8'h08,
  parameter int SLOT_NUM    = 8'h10,
  parameter int SCRATCH_NUM = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [15:0]       wdata,
  input  logic [SLOT_W-1:0] slot_strap,
  output logic [15:0]       rdata
);
  localparam int IDX_W = PTR_W - 2;
  localparam int HI_W  = MASK_BITS - 16;
  localparam logic [IDX_W-1:0] MASK_IDX    = IDX_W'(MASK_NUM >> 2);
  localparam logic [IDX_W-1:0] SLOT_IDX    = IDX_W'(SLOT_NUM >> 2);
  localparam logic [IDX_W-1:0] SCRATCH_IDX = IDX_W'(SCRATCH_NUM >> 2);

  logic [PTR_W-1:0]     ptr_q;
  logic [MASK_BITS-1:0] mask_q;
  logic [31:0]          scratch_q;
  logic [31:0]          reg_val;

  wire             ptr_sel  = strobe && (addr == 3'd0);
  wire             data_sel = strobe && (addr == 3'd4);
  wire [IDX_W-1:0] idx      = ptr_q[PTR_W-1:2];
  wire             hi       = ptr_q[1];
  wire [15:0]      half_val = hi ? reg_val[31:16] : reg_val[15:0];

  always_comb begin
    reg_val = '0;
    if (idx == MASK_IDX)         reg_val = {{(32-MASK_BITS){1'b0}}, mask_q};
    else if (idx == SLOT_IDX)    reg_val = {{(32-SLOT_W){1'b0}}, slot_strap};
    else if (idx == SCRATCH_IDX) reg_val = scratch_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_sel && wr_en) begin
      ptr_q <= wdata[PTR_W-1:0];
    end else if (data_sel) begin
      ptr_q[1] <= ~ptr_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      scratch_q <= '0;
    end else if (data_sel && wr_en) begin
      if (idx == MASK_IDX) begin
        if (hi) mask_q[MASK_BITS-1:16] <= wdata[HI_W-1:0];
        else    mask_q[15:0]           <= wdata;
      end
      if (idx == SCRATCH_IDX) begin
        if (hi) scratch_q[31:16] <= wdata;
        else    scratch_q[15:0]  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (ptr_sel && !wr_en) begin
      rdata <= {{(16-PTR_W){1'b0}}, ptr_q};
    end else if (data_sel && !wr_en) begin
      rdata <= half_val;
    end
  end
endmodule

module ind_reg_port_chk #(
  parameter int PTR_W    = 8,
  parameter int SLOT_W   = 4,
  parameter int MASK_NUM = 8'h08,
  parameter int SLOT_NUM = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe,
  input logic [2:0]        addr,
  input logic              wr_en,
  input logic [15:0]       wdata,
  input logic [SLOT_W-1:0] slot_strap,
  input logic [15:0]       rdata,
  input logic [PTR_W-1:0]  ptr_q
);
  localparam logic [PTR_W-3:0] MIDX = (PTR_W-2)'(MASK_NUM >> 2);
  localparam logic [PTR_W-3:0] SIDX = (PTR_W-2)'(SLOT_NUM >> 2);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && wr_en && addr == 3'd0) |=> ptr_q == $past(wdata[PTR_W-1:0]));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && addr == 3'd4) |=>
      (ptr_q[1] != $past(ptr_q[1])) && (ptr_q[PTR_W-1:2] == $past(ptr_q[PTR_W-1:2])) && (ptr_q[0] == $past(ptr_q[0])));

  assert_mask_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wr_en && addr == 3'd4 && ptr_q[PTR_W-1:2] == MIDX && ptr_q[1]) |=> rdata[15:7] == 9'd0);

  assert_slot_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wr_en && addr == 3'd4 && ptr_q[PTR_W-1:2] == SIDX && !ptr_q[1]) |=>
      rdata == {{(16-SLOT_W){1'b0}}, $past(slot_strap)});

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && !wr_en) |=> $stable(rdata));

  assert_ptr_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && (addr == 3'd0 || addr == 3'd4)) |=> $stable(ptr_q));
endmodule

bind ind_reg_port ind_reg_port_chk #(.PTR_W(PTR_W), .SLOT_W(SLOT_W), .MASK_NUM(MASK_NUM), .SLOT_NUM(SLOT_NUM)) chk_i (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .slot_strap(slot_strap), .rdata(rdata), .ptr_q(ptr_q)
);

// File: tb/ind_reg_port_tb.sv
module ind_reg_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        strobe = 0;
  logic [2:0]  addr = '0;
  logic        wr_en = 0;
  logic [15:0] wdata = '0;
  logic [3:0]  slot_strap = 4'hA;
  logic [15:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ind_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .slot_strap(slot_strap), .rdata(rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    strobe = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    strobe = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    strobe = 1; wr_en = 0; addr = a;
    @(negedge clk);
    strobe = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 rdata after reset", rdata, 16'h0000);
    rd(3'd0, v); check("R1 pointer after reset", v, 16'h0000);
    wr(3'd0, 16'h0018);
    rd(3'd4, v); check("R1 scratch low after reset", v, 16'h0000);
    rd(3'd4, v); check("R1 scratch high after reset", v, 16'h0000);
    wr(3'd0, 16'h0008);
    rd(3'd4, v); check("R1 mask low after reset", v, 16'h0000);
  endtask

  task automatic t_pointer;
    logic [15:0] v;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); check("R2 pointer upper byte zero", v, 16'h00FF);
    rd(3'd0, v); check("R2 offset 0 read keeps bit 1", v, 16'h00FF);
    wr(3'd0, 16'h000A);
    rd(3'd0, v); check("R9 pointer bit1 from write", v, 16'h000A);
    rd(3'd4, v);
    rd(3'd0, v); check("R9 toggle starts from written value", v, 16'h0008);
  endtask

  task automatic t_scratch;
    logic [15:0] v;
    wr(3'd0, 16'h0018);
    wr(3'd4, 16'hBEEF);
    wr(3'd4, 16'hCAFE);
    rd(3'd0, v); check("R3 two writes restore bit 1", v, 16'h0018);
    rd(3'd4, v); check("R4 R7 scratch low half", v, 16'hBEEF);
    rd(3'd0, v); check("R3 read toggles bit 1", v, 16'h001A);
    rd(3'd4, v); check("R4 R7 scratch high half", v, 16'hCAFE);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    wr(3'd0, 16'h0008);
    wr(3'd4, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); check("R5 mask low half", v, 16'hFFFF);
    rd(3'd4, v); check("R5 mask high half bits 31:23 zero", v, 16'h007F);
    wr(3'd0, 16'h000A);
    wr(3'd4, 16'h0055);
    wr(3'd0, 16'h000A);
    rd(3'd4, v); check("R5 mask high rewrite", v, 16'h0055);
  endtask

  task automatic t_slot;
    logic [15:0] v;
    wr(3'd0, 16'h0010);
    wr(3'd4, 16'h1234);
    wr(3'd4, 16'h5678);
    rd(3'd4, v); check("R6 slot low half", v, 16'h000A);
    rd(3'd4, v); check("R6 slot high half zero", v, 16'h0000);
    rd(3'd0, v); check("R6 slot writes still toggle", v, 16'h0010);
  endtask

  task automatic t_unimpl;
    logic [15:0] v;
    wr(3'd0, 16'h0020);
    wr(3'd4, 16'h1111);
    wr(3'd4, 16'h2222);
    rd(3'd4, v); check("R8 unimplemented low reads zero", v, 16'h0000);
    rd(3'd4, v); check("R8 unimplemented high reads zero", v, 16'h0000);
    wr(3'd0, 16'h0018);
    rd(3'd4, v); check("R8 scratch untouched", v, 16'hBEEF);
    wr(3'd0, 16'h0008);
    rd(3'd4, v); check("R8 mask untouched", v, 16'hFFFF);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    wr(3'd0, 16'h0018);
    rd(3'd4, v);
    repeat (5) @(negedge clk);
    check("R10 rdata holds when idle", rdata, 16'hBEEF);
    wr(3'd0, 16'h0008);
    check("R10 rdata holds over pointer write", rdata, 16'hBEEF);
    wr(3'd4, 16'h0000);
    check("R10 rdata holds over data write", rdata, 16'hBEEF);
  endtask

  task automatic t_offset;
    logic [15:0] v;
    wr(3'd0, 16'h0018);
    wr(3'd2, 16'h0004);
    wr(3'd6, 16'h9999);
    wr(3'd1, 16'h7777);
    rd(3'd0, v); check("R11 stray offsets keep pointer", v, 16'h0018);
    rd(3'd4, v); check("R11 stray offsets keep scratch", v, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_scratch();
    t_mask();
    t_slot();
    t_unimpl();
    t_hold();
    t_offset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule